// File: doc/BRIEF.md
# Vertical-Update Register Latch Controller

This block keeps two copies of a set of timing-generator configuration registers: a shadow copy that software programs and an active copy that the display pipeline uses. Writes reach only the shadow copy. The shadow values move to the active copy only when a vertical update pulse arrives. The pulse must also find the programming lock released.

The registers are split into three groups: timing-generator settings, output-pipe settings (including the output connection select) and surface settings. Each group has its own pending flag. The flag rises when the group is written and falls when that write has latched. Before software programs anything, it requests the lock. The block grants the lock only when no group still has an update waiting. A new full update therefore cannot start on top of values that have not latched. Software releases the lock once it is done programming, and the next vertical update pulse commits the new values. A disconnect written to the output-pipe group therefore takes effect only at that latch.

Top module: `vupd_latch_ctrl`

## Requirements
- R1: After reset every active register reads zero, all three pending bits are zero, the lock grant is low and ready is high.
- R2: Writes address a register as `{group[1:0], index}`. Group 0 is timing, group 1 is output-pipe and group 2 is surface. Each pending bit sits at the bit position of its group number. A write while the lock is granted sets that group's pending bit on the next cycle and leaves the active outputs unchanged.
- R3: A write presented while the lock grant is low is ignored. It sets no pending bit, and its data never reaches the active outputs at a later latch.
- R4: A vertical update pulse while the lock is granted transfers nothing, and the pending bits keep their values.
- R5: A vertical update pulse while the grant is low copies the shadow values of every pending group to the active outputs on the next cycle and clears all pending bits.
- R6: The grant rises one cycle after a lock request only when all pending bits are zero. While any pending bit is set, a request is held off.
- R7: The grant falls one cycle after the lock request is withdrawn.
- R8: Ready is high exactly when the grant is low and all pending bits are zero.
- R9: A write with group code 3 is ignored. It changes no pending bit and no active register.
- R10: Within one update the last value written to a register is the value that latches, and all registers written in a group latch together at the same pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_req | input | 1 | Software request to hold the programming lock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address `{group, index}` |
| wr_data | input | 16 | Write data |
| vupdate | input | 1 | Vertical update pulse |
| lock_grant | output | 1 | Lock currently held by software |
| active_regs | output | 192 | Active registers; group g, index i at bits `[(g*4+i)*16 +: 16]` |
| pending | output | 3 | Per-group pending update flags |
| ready | output | 1 | Idle: lock free and nothing pending |

## Verification
The assertions take the vertical update pulse to be a single-cycle strobe at any point in the frame, including while the lock is held. They expect software to write only through the granted lock. The stimulus still drives writes without the grant and with the reserved group code, to show that both are dropped. It also drives pulses both under the lock and while a lock request is being held off. Every input changes on the falling clock edge, so each rising edge sees stable values.

// File: rtl/vupd_latch_pkg.sv
package vupd_latch_pkg;
  localparam int unsigned NUM_GROUPS = 3;
  localparam int unsigned GRP_W      = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_TIMING  = 2'd0,
    GRP_OUTPIPE = 2'd1,
    GRP_SURFACE = 2'd2,
    GRP_RSVD    = 2'd3
  } grp_e;
endpackage

// File: rtl/vupd_lock_arb.sv
module vupd_lock_arb #(
  parameter int unsigned NGRP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_req,
  input  logic [NGRP-1:0] pending,
  output logic            grant
);
  logic grant_d;
  logic grant_q;

  always_comb begin
    grant_d = grant_q;
    if (!lock_req) begin
      grant_d = 1'b0;
    end else if (!grant_q && (pending == '0)) begin
      grant_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= grant_d;
  end

  assign grant = grant_q;

  AST_GRANT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_q && (pending != '0)) |=> !grant_q); // R6
  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_req |=> !grant_q); // R7
endmodule

// File: rtl/vupd_reg_group.sv
module vupd_reg_group #(
  parameter int unsigned REGS   = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grant,
  input  logic                   wr_hit,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   commit,
  output logic [REGS*DATA_W-1:0] active_flat,
  output logic                   pending
);
  logic [DATA_W-1:0] shadow_q [REGS];
  logic [DATA_W-1:0] active_q [REGS];
  logic              pend_d;
  logic              pend_q;
  logic              xfer_en;

  assign xfer_en = commit && pend_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_hit)      pend_d = 1'b1;
    else if (commit) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  for (genvar i = 0; i < REGS; i++) begin : g_reg
    logic wr_sel;
    assign wr_sel = wr_hit && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= '0;
      end else if (wr_sel) begin
        shadow_q[i] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q[i] <= '0;
      end else if (xfer_en) begin
        active_q[i] <= shadow_q[i];
      end
    end

    assign active_flat[i*DATA_W +: DATA_W] = active_q[i];
  end

  assign pending = pend_q;

  AST_WR_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> grant); // R3
  AST_PEND_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !wr_hit) |=> $stable(pend_q)); // R4
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_q); // R5
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_flat)); // R2
endmodule

// File: rtl/vupd_latch_ctrl.sv
module vupd_latch_ctrl #(
  parameter int unsigned REGS_PER_GROUP = 4,
  parameter int unsigned DATA_W         = 16,
  localparam int unsigned NGRP   = vupd_latch_pkg::NUM_GROUPS,
  localparam int unsigned GRP_W  = vupd_latch_pkg::GRP_W,
  localparam int unsigned IDX_W  = (REGS_PER_GROUP > 1) ? $clog2(REGS_PER_GROUP) : 1,
  localparam int unsigned ADDR_W = GRP_W + IDX_W,
  localparam int unsigned GRP_BITS = REGS_PER_GROUP * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock_req,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     vupdate,
  output logic                     lock_grant,
  output logic [NGRP*GRP_BITS-1:0] active_regs,
  output logic [NGRP-1:0]          pending,
  output logic                     ready
);
  import vupd_latch_pkg::*;

  logic             grant;
  logic             wr_ok;
  logic             commit;
  grp_e             wr_grp;
  logic [IDX_W-1:0] wr_idx;
  logic [NGRP-1:0]  pend_vec;

  assign wr_grp = grp_e'(wr_addr[ADDR_W-1 -: GRP_W]);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign wr_ok  = wr_en && grant;
  assign commit = vupdate && !grant;

  vupd_lock_arb #(.NGRP(NGRP)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_req (lock_req),
    .pending  (pend_vec),
    .grant    (grant)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = wr_ok && (wr_grp == grp_e'(g));

    vupd_reg_group #(.REGS(REGS_PER_GROUP), .DATA_W(DATA_W)) u_grp (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant       (grant),
      .wr_hit      (hit),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .commit      (commit),
      .active_flat (active_regs[g*GRP_BITS +: GRP_BITS]),
      .pending     (pend_vec[g])
    );
  end

  assign lock_grant = grant;
  assign pending    = pend_vec;
  assign ready      = !grant && (pend_vec == '0);

  AST_NO_XFER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && vupdate) |=> $stable(active_regs)); // R4
  AST_RSVD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_grp == GRP_RSVD) && !vupdate) |=> $stable(active_regs)); // R9
  AST_COMMIT_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (pend_vec == '0)); // R5
endmodule

// File: tb/vupd_latch_ctrl_tb.sv
module vupd_latch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         lock_req, wr_en, vupdate;
  logic [3:0]   wr_addr;
  logic [15:0]  wr_data;
  logic         lock_grant, ready;
  logic [191:0] active_regs;
  logic [2:0]   pending;

  int n_chk = 0;
  int n_err = 0;

  // row: lock_req, wr_en, addr[4], data[16], vupdate, exp_pend[3], exp_grant, exp_ready
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'h0, 16'h0000, 1'b0, 3'b000, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'h1, 16'hA1A1, 1'b0, 3'b001, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'h0, 16'h0000, 1'b1, 3'b001, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'hB, 16'hC3C3, 1'b0, 3'b101, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'hC, 16'hDEAD, 1'b0, 3'b101, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'h0, 16'h0000, 1'b0, 3'b101, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'h0, 16'h0000, 1'b0, 3'b101, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'h4, 16'h5555, 1'b0, 3'b101, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'h0, 16'h0000, 1'b1, 3'b000, 1'b0, 1'b1},
    {1'b1, 1'b0, 4'h0, 16'h0000, 1'b0, 3'b000, 1'b1, 1'b0}
  };
  localparam string VTAG [NV] = '{"R6", "R2", "R4", "R2", "R9", "R7", "R6", "R3", "R5", "R8"};

  vupd_latch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .vupdate(vupdate),
    .lock_grant(lock_grant), .active_regs(active_regs),
    .pending(pending), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] act(input int g, input int i);
    return active_regs[(g*4+i)*16 +: 16];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // drive on a falling edge, result visible at the following falling edge
  task automatic step(input logic lr, input logic we, input logic [3:0] ad,
                      input logic [15:0] dt, input logic vu);
    lock_req = lr; wr_en = we; wr_addr = ad; wr_data = dt; vupdate = vu;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lock_req = 0; wr_en = 0; wr_addr = 0; wr_data = 0; vupdate = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "active", 32'(active_regs == '0), 32'd1);
    check("R1", "pending", 32'(pending), 32'd0);
    check("R1", "grant", 32'(lock_grant), 32'd0);
    check("R1", "ready", 32'(ready), 32'd1);

    for (int k = 0; k < NV; k++) begin
      logic [27:0] v;
      v = VEC[k];
      step(v[27], v[26], v[25:22], v[21:6], v[5]);
      check(VTAG[k], "pending", 32'(pending), 32'(v[4:2]));
      check(VTAG[k], "grant", 32'(lock_grant), 32'(v[1]));
      check("R8", "ready", 32'(ready), 32'(v[0]));
      if (k == 2) check("R4", "no transfer while locked", 32'(act(0, 1)), 32'h0);
      if (k == 4) check("R2", "active before latch", 32'(act(2, 3)), 32'h0);
    end

    check("R5", "timing g0 i1", 32'(act(0, 1)), 32'hA1A1);
    check("R5", "surface g2 i3", 32'(act(2, 3)), 32'hC3C3);
    check("R3", "ignored write g1 i0", 32'(act(1, 0)), 32'h0);

    // R10: grant is held from the last row; last write wins, group latches together
    step(1, 1, 4'h6, 16'h1111, 0);
    step(1, 1, 4'h6, 16'h2222, 0);
    step(1, 1, 4'h4, 16'h3333, 0);
    check("R2", "pending output-pipe", 32'(pending), 32'b010);
    step(0, 0, 4'h0, 16'h0, 0);
    check("R10", "before pulse", 32'(act(1, 2)), 32'h0);
    step(0, 0, 4'h0, 16'h0, 1);
    check("R10", "last write g1 i2", 32'(act(1, 2)), 32'h2222);
    check("R10", "same pulse g1 i0", 32'(act(1, 0)), 32'h3333);
    check("R10", "other group kept", 32'(act(0, 1)), 32'hA1A1);
    check("R8", "ready idle", 32'(ready), 32'd1);

    // R1: reset mid-run clears everything
    step(1, 0, 4'h0, 16'h0, 0);
    step(1, 1, 4'h0, 16'h7777, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lock_req = 0; wr_en = 0;
    @(negedge clk);
    check("R1", "active after reset", 32'(active_regs == '0), 32'd1);
    check("R1", "pending after reset", 32'(pending), 32'd0);
    check("R1", "ready after reset", 32'(ready), 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule